// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends a single command byte from a host to a PS/2 device over the shared two-wire link. The host opens a transfer by pulling the clock line low for a fixed request interval. It then drives the data line low as a start bit and lets go of the clock. From that point the device generates every clock edge. The host puts each frame bit on the data line while the clock is low, and keeps it there until the clock returns high.

Both lines are open-drain. The block never drives a line high: it has one drive-low enable per line, and it reads the real line levels back through synchronisers. After the last frame bit the block releases the data line and waits for the device to acknowledge. Only then does it hand the link back to the receive path.

While a transfer is in progress, a companion receiver is told to disregard line activity. When the transfer ends, the receiver's inactivity timer is cleared.

Top module: `ps2_cmd_tx`

## Requirements
- R1: After reset, and at any time when no transfer is active, both drive-low enables are 0, `busy_o` is 0 and `done_o` is 0.
- R2: A start strobe seen while idle asserts the clock drive-low enable for exactly HOLD_CYCLES+1 consecutive cycles. The data drive-low enable is asserted only in the last of those cycles, and it stays asserted after the clock is released (start bit = 0).
- R3: Only after the host has seen the released clock line go high again does it begin answering clock lows. The eight command bits then go out least-significant bit first. Each bit is placed on the data line (drive-low enable = inverse of the bit) after the host sees the clock low, and it is held until the host sees the clock high.
- R4: The ninth frame bit is an odd-parity bit. It is 1 when the command byte contains an even number of ones, and 0 otherwise.
- R5: After the parity bit's high phase, the host releases the data line at the next clock low. The device therefore reads a stop bit of 1.
- R6: Once the data line has been seen high after that release, the transfer finishes only after the data line is seen low (acknowledge) and then the clock line is seen low. `done_o` is a one-cycle pulse, and `busy_o` is 0 in that cycle.
- R7: A start strobe that arrives while `busy_o` is 1 is ignored. The byte in flight is unchanged, and no new transfer follows.
- R8: `rx_inhibit_o` equals `busy_o` in every cycle. `rx_timer_clr_o` pulses for one cycle, in the same cycle as `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to send `cmd_byte_i` |
| cmd_byte_i | input | 8 | Command byte, captured with the start strobe |
| ps2_clk_i | input | 1 | PS/2 clock line level (asynchronous) |
| ps2_dat_i | input | 1 | PS/2 data line level (asynchronous) |
| ps2_clk_drv_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| ps2_dat_drv_o | output | 1 | 1 pulls the data line low, 0 releases it |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the acknowledge completes |
| rx_inhibit_o | output | 1 | Tells the receiver to ignore line traffic |
| rx_timer_clr_o | output | 1 | One-cycle clear of the receiver inactivity timer |

## Verification
A sequencer that has slipped by one frame position shows up directly in the bits the modelled device samples. The captured byte comes out shifted, the parity is wrong, or the stop bit reads 0, and all of these are visible within the same frame. A state that reads a stale synchronised level shows up as a start bit overwritten before the first device clock, or as `done_o` firing while the acknowledge is still being held off; the stalled-acknowledge case holds the device's acknowledge off for tens of cycles and checks that `done_o` stays quiet. A bad request timer shows up as a wrong count of clock-drive cycles, and that count is measured before the first data bit.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    localparam int FRAME_BITS = 9;
    localparam int BIT_CW     = $clog2(FRAME_BITS + 1);

    typedef enum logic [3:0] {
        TX_IDLE,
        TX_HOLD,
        TX_REQ,
        TX_WAIT_CLK_HI,
        TX_BIT_LOW,
        TX_BIT_HIGH,
        TX_REL,
        TX_WAIT_REL,
        TX_ACK_DAT,
        TX_ACK_CLK
    } tx_state_e;

    typedef struct packed {
        logic [FRAME_BITS-1:0] sh;
        logic [BIT_CW-1:0]     left;
    } tx_frame_t;

    typedef struct packed {
        logic clk_low;
        logic dat_low;
    } line_drv_t;

    function automatic logic odd_parity(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ps2tx_hold_timer.sv
module ps2tx_hold_timer #(
    parameter int CYCLES = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(CYCLES - 1));
endmodule

// File: rtl/ps2tx_frame_seq.sv
module ps2tx_frame_seq
    import ps2tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] cmd_byte,
    input  logic       clk_lvl,
    input  logic       dat_lvl,
    input  logic       hold_done,
    output logic       hold_run,
    output line_drv_t  drv,
    output logic       busy,
    output logic       done
);
    tx_state_e st, st_n;
    tx_frame_t frame, frame_n;
    line_drv_t drv_n;
    logic      done_n;

    always_comb begin
        st_n    = st;
        frame_n = frame;
        drv_n   = drv;
        done_n  = 1'b0;
        unique case (st)
            TX_IDLE: begin
                if (start) begin
                    st_n          = TX_HOLD;
                    frame_n.sh    = {odd_parity(cmd_byte), cmd_byte};
                    frame_n.left  = BIT_CW'(FRAME_BITS);
                    drv_n.clk_low = 1'b1;
                    drv_n.dat_low = 1'b0;
                end
            end
            TX_HOLD: begin
                if (hold_done) begin
                    st_n          = TX_REQ;
                    drv_n.dat_low = 1'b1;
                end
            end
            TX_REQ: begin
                st_n          = TX_WAIT_CLK_HI;
                drv_n.clk_low = 1'b0;
            end
            TX_WAIT_CLK_HI: begin
                if (clk_lvl) st_n = TX_BIT_LOW;
            end
            TX_BIT_LOW: begin
                if (!clk_lvl) begin
                    drv_n.dat_low = ~frame.sh[0];
                    st_n          = TX_BIT_HIGH;
                end
            end
            TX_BIT_HIGH: begin
                if (clk_lvl) begin
                    frame_n.sh   = frame.sh >> 1;
                    frame_n.left = frame.left - 1'b1;
                    st_n = (frame.left == BIT_CW'(1)) ? TX_REL : TX_BIT_LOW;
                end
            end
            TX_REL: begin
                if (!clk_lvl) begin
                    drv_n.dat_low = 1'b0;
                    st_n          = TX_WAIT_REL;
                end
            end
            TX_WAIT_REL: begin
                if (dat_lvl) st_n = TX_ACK_DAT;
            end
            TX_ACK_DAT: begin
                if (!dat_lvl) st_n = TX_ACK_CLK;
            end
            TX_ACK_CLK: begin
                if (!clk_lvl) begin
                    st_n   = TX_IDLE;
                    done_n = 1'b1;
                end
            end
            default: begin
                st_n  = TX_IDLE;
                drv_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= TX_IDLE;
            frame <= '0;
            drv   <= '0;
            done  <= 1'b0;
        end else begin
            st    <= st_n;
            frame <= frame_n;
            drv   <= drv_n;
            done  <= done_n;
        end
    end

    assign hold_run = (st == TX_HOLD);
    assign busy     = (st != TX_IDLE);
endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
    import ps2tx_pkg::*;
#(
    parameter int HOLD_CYCLES = 12500,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [7:0] cmd_byte_i,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       ps2_clk_drv_o,
    output logic       ps2_dat_drv_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       rx_inhibit_o,
    output logic       rx_timer_clr_o
);
    logic [1:0] lvl;
    logic       hold_run;
    logic       hold_done;
    line_drv_t  drv;

    ps2tx_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({ps2_clk_i, ps2_dat_i}),
        .q   (lvl)
    );

    ps2tx_hold_timer #(
        .CYCLES (HOLD_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .run     (hold_run),
        .expired (hold_done)
    );

    ps2tx_frame_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .cmd_byte  (cmd_byte_i),
        .clk_lvl   (lvl[1]),
        .dat_lvl   (lvl[0]),
        .hold_done (hold_done),
        .hold_run  (hold_run),
        .drv       (drv),
        .busy      (busy_o),
        .done      (done_o)
    );

    assign ps2_clk_drv_o  = drv.clk_low;
    assign ps2_dat_drv_o  = drv.dat_low;
    assign rx_inhibit_o   = busy_o;
    assign rx_timer_clr_o = done_o;
endmodule

// File: rtl/ps2_cmd_tx_chk.sv
module ps2_cmd_tx_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic clk_drv,
    input logic dat_drv
);
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!clk_drv && !dat_drv)); // R1

    AST_REQUEST_CLOCK_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (clk_drv && !dat_drv)); // R2

    AST_START_BIT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $fell(clk_drv)) |-> dat_drv); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6

    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (busy_o || done_o)); // R7
endmodule

bind ps2_cmd_tx ps2_cmd_tx_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .clk_drv (ps2_clk_drv_o),
    .dat_drv (ps2_dat_drv_o)
);

// File: tb/ps2_cmd_tx_tb.sv
`timescale 1ns/1ps
module ps2_cmd_tx_tb_top;
    localparam int HOLD = 50;
    localparam int HALF = 20;
    localparam int WD   = 100000;

    // {expected parity, byte}
    localparam logic [8:0] VEC [8] = '{
        {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b0, 8'h01}, {1'b1, 8'hED},
        {1'b0, 8'hF4}, {1'b1, 8'hAA}, {1'b0, 8'h80}, {1'b0, 8'h7F}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] cmd = '0;
    logic       dev_clk_low = 1'b0;
    logic       dev_dat_low = 1'b0;
    logic       clk_drv, dat_drv, busy, done, inhibit, tclr;

    wire clk_line = !(clk_drv | dev_clk_low);
    wire dat_line = !(dat_drv | dev_dat_low);

    int nchk = 0;
    int nfail = 0;
    int done_cnt = 0;
    int inh_bad = 0;
    int clr_bad = 0;

    always #4 clk = ~clk;

    ps2_cmd_tx #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start),
        .cmd_byte_i     (cmd),
        .ps2_clk_i      (clk_line),
        .ps2_dat_i      (dat_line),
        .ps2_clk_drv_o  (clk_drv),
        .ps2_dat_drv_o  (dat_drv),
        .busy_o         (busy),
        .done_o         (done),
        .rx_inhibit_o   (inhibit),
        .rx_timer_clr_o (tclr)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_cnt++;
            if (inhibit != busy) inh_bad++;
            if (tclr != done) clr_bad++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        start = 1'b1;
        cmd   = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Device model: measures the request, clocks 10 bits, then acknowledges.
    task automatic dev_xfer(input int ack_delay, output logic [9:0] bits,
                            output int hold_len, output int dat_in_hold,
                            output logic dat_last);
        int base;
        hold_len = 0;
        dat_in_hold = 0;
        dat_last = 1'b0;
        while (!clk_drv) @(negedge clk);
        while (clk_drv) begin
            hold_len++;
            dat_last = dat_drv;
            if (dat_drv) dat_in_hold++;
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            dev_clk_low = 1'b1;
            repeat (HALF) @(negedge clk);
            bits[i] = dat_line;
            dev_clk_low = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        base = done_cnt;
        dev_dat_low = 1'b1;
        if (ack_delay > 0) begin
            repeat (ack_delay) @(negedge clk);
            check(done_cnt == base && busy, "R6 ack-data-only", done_cnt - base, 0);
        end
        repeat (4) @(negedge clk);
        dev_clk_low = 1'b1;
        repeat (10) @(negedge clk);
        check(done_cnt == base + 1, "R6 done-pulse", done_cnt - base, 1);
        check(!busy, "R6 busy-cleared", busy, 0);
        dev_clk_low = 1'b0;
        dev_dat_low = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        logic [9:0] bits;
        int hl, dih;
        logic dl;

        repeat (3) @(negedge clk);
        check(!clk_drv && !dat_drv && !busy && !done, "R1 in-reset",
              {clk_drv, dat_drv, busy, done}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(!clk_drv && !dat_drv && !busy && !done, "R1 after-reset",
              {clk_drv, dat_drv, busy, done}, 0);

        foreach (VEC[k]) begin
            send(VEC[k][7:0]);
            dev_xfer(0, bits, hl, dih, dl);
            check(hl == HOLD + 1, "R2 hold-length", hl, HOLD + 1);
            check(dih == 1 && dl, "R2 start-bit", dih, 1);
            check(bits[7:0] == VEC[k][7:0], "R3 data-lsb-first", bits[7:0], VEC[k][7:0]);
            check(bits[8] == VEC[k][8], "R4 parity", bits[8], VEC[k][8]);
            check(bits[9] == 1'b1, "R5 stop-released", bits[9], 1);
        end

        // R6: acknowledge data low held for a long time before clock low
        send(8'h5A);
        dev_xfer(40, bits, hl, dih, dl);
        check(bits[7:0] == 8'h5A && bits[8] == 1'b1, "R6 delayed-ack frame",
              bits[8:0], 9'h15A);

        // R7: second start strobe inside the request hold
        fork
            begin
                send(8'hA5);
                dev_xfer(0, bits, hl, dih, dl);
            end
            begin
                @(negedge clk);
                @(negedge clk);
                repeat (20) @(negedge clk);
                start = 1'b1;
                cmd   = 8'h3C;
                @(negedge clk);
                start = 1'b0;
            end
        join
        check(bits[7:0] == 8'hA5, "R7 byte-unchanged", bits[7:0], 8'hA5);
        check(bits[8] == 1'b1, "R7 parity-unchanged", bits[8], 1);
        begin
            int extra = 0;
            for (int c = 0; c < 80; c++) begin
                @(negedge clk);
                if (clk_drv || busy) extra++;
            end
            check(extra == 0, "R7 no-second-transfer", extra, 0);
        end

        check(inh_bad == 0, "R8 inhibit-equals-busy", inh_bad, 0);
        check(clr_bad == 0, "R8 timer-clear-with-done", clr_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule